// File: doc/BRIEF.md
# Speculative Window Weight Fetch Gate

This block keeps a running weight over the instructions that have been decoded but have not yet executed, and stops fetch and decode together while that weight stays above a fixed threshold. Each decoded instruction adds a contribution that depends on its class and, for conditional and indirect branches, on a confidence bit. The per-class contributions arrive on an input table, so they can be constants or values that another block trains. The block returns each lane's contribution so that the back-end can store it with the instruction. When the instruction executes, the back-end sends that stored value back to be subtracted.

Up to four instructions decode and up to four execute in each cycle. When a branch misprediction is recovered, the weight is not rebuilt. It is reset to the contributions decoded in that same cycle. The tag of the recovered branch is kept as an anchor. Any later execution report whose tag is not younger than the anchor is dropped, because its contribution was already discarded by the reset. Tags carry one wrap bit beyond the window index, and age is taken from the sign of the modular tag difference.

The gate is a two-state machine. In state OPEN the gate output is low. OPEN moves to GATED when the next weight is strictly above the threshold. In state GATED the gate output is high. GATED moves back to OPEN when the next weight is strictly below the threshold. At a weight exactly equal to the threshold the machine stays in its current state. The threshold is captured from a configuration input while reset is held.

Top module: `spec_window_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, the weight is zero and fetch_gate is low.
- R2: dec_contrib of a lane is zero when that lane is not valid. Otherwise it is the class_weight slot chosen by class and confidence. The class codes are 0 non-branch, 1 unconditional direct, 2 return, 3 conditional and 4 indirect, and codes 5 to 7 count as non-branch. The slots are 0 non-branch, 1 unconditional, 2 return, 3 conditional high-confidence, 4 conditional low-confidence, 5 indirect high-confidence and 6 indirect low-confidence. A confidence bit of 1 means high confidence.
- R3: In each cycle without a recovery, the weight gains the sum of the valid lanes' contributions and loses the sum of the execution contributions that count.
- R4: After any clock edge, fetch_gate is high when the registered weight is strictly greater than the threshold.
- R5: After any clock edge, fetch_gate is low when the registered weight is strictly less than the threshold.
- R6: When the registered weight equals the threshold, fetch_gate keeps the value it had in the previous cycle.
- R7: In a cycle with rcv_valid, the weight becomes exactly that cycle's decoded contributions, and every execution report of that cycle is ignored.
- R8: After a recovery, an execution report is subtracted only when its tag is younger than the recovered tag. Younger means that (tag minus anchor) modulo 2^TAGW is non-zero and has a clear top bit, which also holds across wraparound.
- R9: Before the first recovery after reset, every valid execution report is subtracted.
- R10: The weight saturates at zero when a subtraction would make it negative, and at 2^WW-1 when an addition would overflow it.
- R11: The threshold is the value of cfg_threshold during reset, and later changes to cfg_threshold have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; threshold is captured while low |
| cfg_threshold | input | WW | Gate threshold, sampled during reset |
| class_weight | input | 7 x CW | Contribution per slot (non-branch, unconditional, return, cond hi/lo, indirect hi/lo) |
| dec_valid | input | LANES | Decode lane valid |
| dec_class | input | LANES x 3 | Instruction class code per decode lane |
| dec_hi_conf | input | LANES | High-confidence prediction per decode lane |
| ex_valid | input | LANES | Execution report valid |
| ex_tag | input | LANES x TAGW | Program-order tag of the executed instruction, with wrap bit |
| ex_contrib | input | LANES x CW | Stored contribution of the executed instruction |
| rcv_valid | input | 1 | Misprediction recovery event |
| rcv_tag | input | TAGW | Tag of the recovered branch |
| fetch_gate | output | 1 | High stops fetch and decode |
| dec_contrib | output | LANES x CW | Contribution of each decoded instruction, to be stored by the back-end |

## Verification
The assertions rely on two things about the inputs. The back-end must return each instruction's stored contribution unchanged, and the tag of every execution report must lie within half the tag space of the current anchor, so that the sign of the difference gives its age correctly. The stimulus builds execution tags as small offsets of up to 30 around the most recent recovered tag. Its fixed sequences place weights exactly on, one above and one below the threshold, and across tag wraparound. A reference model of the weight, anchor and gate is compared on every clock, including a phase in which all contributions are raised to their maximum to drive the weight into its upper bound.

// File: rtl/sww_pkg.sv
package sww_pkg;

    typedef enum logic [2:0] {
        CL_PLAIN = 3'd0,
        CL_JUMP  = 3'd1,
        CL_RET   = 3'd2,
        CL_COND  = 3'd3,
        CL_IND   = 3'd4
    } iclass_e;

    typedef enum logic {
        GS_OPEN  = 1'b0,
        GS_GATED = 1'b1
    } gate_state_e;

    localparam int unsigned NSLOT   = 7;
    localparam int unsigned SLOTW   = 3;

    localparam logic [SLOTW-1:0] SL_PLAIN   = 3'd0;
    localparam logic [SLOTW-1:0] SL_JUMP    = 3'd1;
    localparam logic [SLOTW-1:0] SL_RET     = 3'd2;
    localparam logic [SLOTW-1:0] SL_COND_HI = 3'd3;
    localparam logic [SLOTW-1:0] SL_COND_LO = 3'd4;
    localparam logic [SLOTW-1:0] SL_IND_HI  = 3'd5;
    localparam logic [SLOTW-1:0] SL_IND_LO  = 3'd6;

    function automatic logic [SLOTW-1:0] slot_of(input logic [2:0] cls, input logic hi_conf);
        logic [SLOTW-1:0] s;
        case (iclass_e'(cls))
            CL_JUMP: s = SL_JUMP;
            CL_RET:  s = SL_RET;
            CL_COND: s = hi_conf ? SL_COND_HI : SL_COND_LO;
            CL_IND:  s = hi_conf ? SL_IND_HI  : SL_IND_LO;
            default: s = SL_PLAIN;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sww_contrib_lut.sv
module sww_contrib_lut
    import sww_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic                        valid,
    input  logic [2:0]                  cls,
    input  logic                        hi_conf,
    input  logic [NSLOT-1:0][CW-1:0]    table_in,
    output logic [CW-1:0]               contrib
);
    logic [SLOTW-1:0] slot;

    always_comb begin
        slot    = slot_of(cls, hi_conf);
        contrib = valid ? table_in[slot] : '0;
    end
endmodule

// File: rtl/sww_age_filter.sv
module sww_age_filter #(
    parameter int TAGW = 8,
    parameter int CW   = 7
) (
    input  logic             valid,
    input  logic [TAGW-1:0]  tag,
    input  logic             anchor_vld,
    input  logic [TAGW-1:0]  anchor_tag,
    input  logic [CW-1:0]    contrib,
    output logic [CW-1:0]    counted
);
    logic [TAGW-1:0] diff;
    logic            younger;

    always_comb begin
        diff    = tag - anchor_tag;
        younger = (diff != '0) && !diff[TAGW-1];
        counted = (valid && (!anchor_vld || younger)) ? contrib : '0;
    end
endmodule

// File: rtl/sww_weight_acc.sv
module sww_weight_acc #(
    parameter int LANES = 4,
    parameter int CW    = 7,
    parameter int WW    = 12
) (
    input  logic [WW-1:0]               cur,
    input  logic                        clear,
    input  logic [LANES-1:0][CW-1:0]    add_c,
    input  logic [LANES-1:0][CW-1:0]    sub_c,
    output logic [WW-1:0]               nxt
);
    localparam int SUMW = CW + $clog2(LANES) + 1;
    localparam int EXTW = ((SUMW > WW) ? SUMW : WW) + 2;
    localparam logic [EXTW-1:0] CEIL = EXTW'((1 << WW) - 1);

    logic [EXTW-1:0] add_s;
    logic [EXTW-1:0] sub_s;
    logic [EXTW-1:0] grown;
    logic [EXTW-1:0] left;

    always_comb begin
        add_s = '0;
        sub_s = '0;
        for (int i = 0; i < LANES; i++) begin
            add_s = add_s + EXTW'(add_c[i]);
            sub_s = sub_s + EXTW'(sub_c[i]);
        end
        if (clear) begin
            grown = add_s;
            sub_s = '0;
        end else begin
            grown = EXTW'(cur) + add_s;
        end
        left = grown - sub_s;
        if (grown <= sub_s)     nxt = '0;
        else if (left > CEIL)   nxt = '1;
        else                    nxt = WW'(left);
    end
endmodule

// File: rtl/spec_window_gate.sv
module spec_window_gate
    import sww_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int CW        = 7,
    parameter int WW        = 12,
    parameter int ROB_DEPTH = 128,
    localparam int TAGW     = $clog2(ROB_DEPTH) + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WW-1:0]                cfg_threshold,
    input  logic [NSLOT-1:0][CW-1:0]     class_weight,
    input  logic [LANES-1:0]             dec_valid,
    input  logic [LANES-1:0][2:0]        dec_class,
    input  logic [LANES-1:0]             dec_hi_conf,
    input  logic [LANES-1:0]             ex_valid,
    input  logic [LANES-1:0][TAGW-1:0]   ex_tag,
    input  logic [LANES-1:0][CW-1:0]     ex_contrib,
    input  logic                         rcv_valid,
    input  logic [TAGW-1:0]              rcv_tag,
    output logic                         fetch_gate,
    output logic [LANES-1:0][CW-1:0]     dec_contrib
);
    gate_state_e             state_q, state_d;
    logic [WW-1:0]           weight_q, weight_d;
    logic [WW-1:0]           thr_q;
    logic [TAGW-1:0]         anchor_q;
    logic                    anchor_vld_q;
    logic [LANES-1:0][CW-1:0] ex_counted;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sww_contrib_lut #(.CW(CW)) u_lut (
            .valid    (dec_valid[g]),
            .cls      (dec_class[g]),
            .hi_conf  (dec_hi_conf[g]),
            .table_in (class_weight),
            .contrib  (dec_contrib[g])
        );
        sww_age_filter #(.TAGW(TAGW), .CW(CW)) u_age (
            .valid      (ex_valid[g]),
            .tag        (ex_tag[g]),
            .anchor_vld (anchor_vld_q),
            .anchor_tag (anchor_q),
            .contrib    (ex_contrib[g]),
            .counted    (ex_counted[g])
        );
    end

    sww_weight_acc #(.LANES(LANES), .CW(CW), .WW(WW)) u_acc (
        .cur   (weight_q),
        .clear (rcv_valid),
        .add_c (dec_contrib),
        .sub_c (ex_counted),
        .nxt   (weight_d)
    );

    // Next-state logic of the gate machine, driven by the next weight
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_OPEN:  if (weight_d > thr_q) state_d = GS_GATED;
            GS_GATED: if (weight_d < thr_q) state_d = GS_OPEN;
        endcase
    end

    // State register and window bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= GS_OPEN;
            weight_q     <= '0;
            thr_q        <= cfg_threshold;
            anchor_q     <= '0;
            anchor_vld_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            weight_q <= weight_d;
            if (rcv_valid) begin
                anchor_q     <= rcv_tag;
                anchor_vld_q <= 1'b1;
            end
        end
    end

    // Output decode of the gate machine
    always_comb begin
        unique case (state_q)
            GS_OPEN:  fetch_gate = 1'b0;
            GS_GATED: fetch_gate = 1'b1;
        endcase
    end
endmodule

// File: rtl/sww_checker.sv
module sww_checker #(
    parameter int LANES = 4,
    parameter int CW    = 7,
    parameter int WW    = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       gate,
    input logic [WW-1:0]              weight,
    input logic [WW-1:0]              thr,
    input logic                       rcv_valid,
    input logic [LANES-1:0]           dec_valid,
    input logic [LANES-1:0][CW-1:0]   dec_contrib
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (weight == '0 && !gate));

    p_idle_lane_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid == '0) |-> (dec_contrib == '0));

    p_gate_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (weight > thr) |-> gate);

    p_gate_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (weight < thr) |-> !gate);

    p_gate_hold_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (weight == thr && $past(rst_n)) |-> (gate == $past(gate)));

    p_recover_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_valid && dec_valid == '0) |=> (weight == '0));

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rcv_valid && dec_valid == '0) |=> (weight <= $past(weight)));

    p_threshold_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(thr));
endmodule

bind spec_window_gate sww_checker #(.LANES(LANES), .CW(CW), .WW(WW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate        (fetch_gate),
    .weight      (weight_q),
    .thr         (thr_q),
    .rcv_valid   (rcv_valid),
    .dec_valid   (dec_valid),
    .dec_contrib (dec_contrib)
);

// File: tb/spec_window_gate_test.sv
module spec_window_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int CW    = 7;
    localparam int WW    = 12;
    localparam int TAGW  = 8;
    localparam int WMAX  = (1 << WW) - 1;

    logic                        clk = 1'b0;
    logic                        rst_n;
    logic [WW-1:0]               cfg_threshold;
    logic [6:0][CW-1:0]          class_weight;
    logic [LANES-1:0]            dec_valid;
    logic [LANES-1:0][2:0]       dec_class;
    logic [LANES-1:0]            dec_hi_conf;
    logic [LANES-1:0]            ex_valid;
    logic [LANES-1:0][TAGW-1:0]  ex_tag;
    logic [LANES-1:0][CW-1:0]    ex_contrib;
    logic                        rcv_valid;
    logic [TAGW-1:0]             rcv_tag;
    logic                        fetch_gate;
    logic [LANES-1:0][CW-1:0]    dec_contrib;

    int n_cmp = 0;
    int n_bad = 0;
    int m_w, m_thr, m_anchor;
    bit m_g, m_have;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_window_gate #(.LANES(LANES), .CW(CW), .WW(WW), .ROB_DEPTH(128)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold),
        .class_weight(class_weight), .dec_valid(dec_valid), .dec_class(dec_class),
        .dec_hi_conf(dec_hi_conf), .ex_valid(ex_valid), .ex_tag(ex_tag),
        .ex_contrib(ex_contrib), .rcv_valid(rcv_valid), .rcv_tag(rcv_tag),
        .fetch_gate(fetch_gate), .dec_contrib(dec_contrib)
    );

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_table(input int v0, v1, v2, v3, v4, v5, v6);
        class_weight[0] = CW'(v0); class_weight[1] = CW'(v1); class_weight[2] = CW'(v2);
        class_weight[3] = CW'(v3); class_weight[4] = CW'(v4); class_weight[5] = CW'(v5);
        class_weight[6] = CW'(v6);
    endtask

    function automatic int ref_contrib(input bit v, input int cls, input bit hi);
        int s;
        if (!v) return 0;
        case (cls)
            1: s = 1;
            2: s = 2;
            3: s = hi ? 3 : 4;
            4: s = hi ? 5 : 6;
            default: s = 0;
        endcase
        return int'(class_weight[s]);
    endfunction

    function automatic bit is_younger(input int tag, input int anc);
        int d;
        d = (tag - anc) & ((1 << TAGW) - 1);
        return (d != 0) && (d < (1 << (TAGW - 1)));
    endfunction

    task automatic idle();
        dec_valid = '0; dec_class = '0; dec_hi_conf = '0;
        ex_valid = '0; ex_tag = '0; ex_contrib = '0;
        rcv_valid = 1'b0; rcv_tag = '0;
    endtask

    task automatic dec(input int lane, input int cls, input bit hi);
        dec_valid[lane] = 1'b1; dec_class[lane] = 3'(cls); dec_hi_conf[lane] = hi;
    endtask

    task automatic exe(input int lane, input int tag, input int c);
        ex_valid[lane] = 1'b1; ex_tag[lane] = TAGW'(tag); ex_contrib[lane] = CW'(c);
    endtask

    task automatic recover(input int tag);
        rcv_valid = 1'b1; rcv_tag = TAGW'(tag);
    endtask

    // Applies the driven inputs for one clock and compares the outputs
    task automatic step(input string req);
        int add, sub, nw;
        #1;
        add = 0; sub = 0;
        for (int i = 0; i < LANES; i++) begin
            int e;
            e = ref_contrib(dec_valid[i], int'(dec_class[i]), dec_hi_conf[i]);
            check("R2", "dec_contrib", int'(dec_contrib[i]), e);
            add += e;
            if (!rcv_valid && ex_valid[i] && (!m_have || is_younger(int'(ex_tag[i]), m_anchor)))
                sub += int'(ex_contrib[i]);
        end
        nw = rcv_valid ? add : m_w + add;
        nw = (nw < sub) ? 0 : nw - sub;
        if (nw > WMAX) nw = WMAX;
        if (rcv_valid) begin
            m_have = 1'b1;
            m_anchor = int'(rcv_tag);
        end
        @(posedge clk);
        #1;
        m_w = nw;
        if (m_w > m_thr) m_g = 1'b1;
        else if (m_w < m_thr) m_g = 1'b0;
        check(req, "fetch_gate", int'(fetch_gate), int'(m_g));
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        idle();
        set_table(1, 1, 8, 8, 40, 8, 40);
        rst_n = 1'b0;
        cfg_threshold = WW'(160);
        m_w = 0; m_thr = 160; m_g = 1'b0; m_have = 1'b0; m_anchor = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "fetch_gate in reset", int'(fetch_gate), 0);
        rst_n = 1'b1;
        // R11: a later threshold value must have no effect
        cfg_threshold = WW'(5);
        step("R1");

        // R2: every class code and confidence value on the lanes
        dec(0, 0, 0); dec(1, 1, 1); dec(2, 2, 0); dec(3, 5, 1); step("R2");
        dec(0, 3, 1); dec(1, 3, 0); dec(2, 4, 1); dec(3, 4, 0); step("R2");
        dec(1, 6, 0); dec(3, 7, 1); step("R2");
        // weight now 1+1+8+1+8+40+8+40+1+1 = 109; bring it to zero
        exe(0, 10, 109); step("R9");

        // R6, R4, R5 around the threshold of 160
        for (int i = 0; i < LANES; i++) dec(i, 3, 0);
        step("R6");
        dec(0, 0, 0); step("R4");
        exe(0, 30, 1); step("R6");
        exe(1, 31, 1); step("R5");

        // R7: recovery with decodes and executions in the same cycle
        for (int i = 0; i < LANES; i++) dec(i, 3, 0);
        step("R3");
        for (int i = 0; i < LANES; i++) dec(i, 4, 0);
        step("R3");
        dec(0, 0, 0); dec(1, 0, 0); exe(2, 210, 40); recover(200); step("R7");

        // R8: age filtering against the recovered tag 200
        for (int i = 0; i < LANES; i++) dec(i, 3, 0);
        step("R4");
        exe(0, 190, 40); step("R8");
        exe(1, 200, 40); step("R8");
        exe(2, 205, 3); step("R8");

        // R8 across wraparound, anchor 250
        recover(250); step("R7");
        for (int i = 0; i < LANES; i++) dec(i, 3, 0);
        dec(0, 0, 0); dec(1, 3, 0); dec(2, 3, 0); dec(3, 3, 0);
        step("R6");
        for (int i = 0; i < LANES; i++) dec(i, 0, 0);
        step("R4");
        exe(0, 3, 5); step("R8");
        dec(0, 0, 0); dec(1, 0, 0); dec(2, 0, 0); step("R4");
        exe(3, 245, 100); step("R8");

        // R10: subtraction below zero saturates
        recover(10); step("R7");
        for (int i = 0; i < LANES; i++) dec(i, 0, 0);
        step("R3");
        exe(0, 20, 100); step("R10");
        for (int i = 0; i < LANES; i++) dec(i, 3, 0);
        step("R10");
        dec(0, 0, 0); step("R10");

        // R10: addition saturates at the top
        set_table(127, 127, 127, 127, 127, 127, 127);
        recover(0); step("R7");
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < LANES; i++) dec(i, 0, 0);
            step("R10");
        end
        for (int k = 0; k < 10; k++) begin
            for (int i = 0; i < LANES; i++) exe(i, 5, 127);
            step("R10");
        end
        set_table(1, 1, 8, 8, 40, 8, 40);
        recover(0); step("R7");

        // R3 with mixed traffic around the anchor
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < LANES; i++) begin
                if ($urandom_range(0, 1) == 1) dec(i, $urandom_range(0, 7), 1'($urandom_range(0, 1)));
                if ($urandom_range(0, 2) == 0)
                    exe(i, (m_anchor + $urandom_range(0, 60) - 30) & 255, $urandom_range(0, 60));
            end
            if ($urandom_range(0, 15) == 0) recover((m_anchor + $urandom_range(0, 40)) & 255);
            step("R3");
        end

        report();
        $finish;
    end
endmodule